// File: doc/BRIEF.md
# Magnitude Compare and Condition-Branch Unit

This unit holds an 8-bit condition-code register and does the two steps of a vertex clip test. In the compare step it compares the absolute value of operand A with the absolute value of operand B and writes the result into the register. Because the sign bits are dropped, one test of |x| <= |w| does the work of the two bound tests x >= -w and x <= w.

Three operand formats are supported:
- single precision, using the low 32 bits of each operand;
- double precision, using all 64 bits;
- paired single, where each 64-bit operand carries two 32-bit lanes that are compared in parallel.

A single-precision or double-precision compare writes one condition bit at the selected index. A paired-single compare writes two adjacent bits.

In the branch step the unit looks at an aligned group of 2 or 4 condition bits. It reports "taken" when any bit in the group is 0 (false variant) or when any bit in the group is 1 (true variant). One branch therefore checks several clip results at once.

Compare writes are registered. The branch decision is a combinational function of the registered bits, so a branch issued in the cycle after a compare sees the result of that compare.

Top module: `magcmp_ccbr_unit`

## Requirements
- R1: While `rst` is high, and after it falls with no compare applied, `cc_out` is all zeros and `br_taken` is 0.
- R2: A single-precision compare (`cmp_fmt`=0) uses bits [31:0] of each operand and ignores both sign bits. On the next clock edge it writes its result to `cc_out[cmp_idx]`, and every other bit keeps its value.
- R3: A double-precision compare (`cmp_fmt`=1) uses all 64 bits of each operand, sign ignored, and writes one bit at `cmp_idx`.
- R4: A paired-single compare (`cmp_fmt`=2) compares lane [31:0] into `cc_out[cmp_idx]` and lane [63:32] into `cc_out[cmp_idx+1]`. Every other bit keeps its value.
- R5: `cmp_pred` selects the relation: 0 is |A| <= |B|, 1 is |A| < |B|, 2 is |A| == |B| (so +0 equals -0), and 3 is unordered (either operand is NaN).
- R6: In a lane where either operand is a NaN, predicates 0, 1 and 2 give 0 and predicate 3 gives 1.
- R7: A compare with `cmp_fmt`=3, or a paired-single compare with an odd `cmp_idx`, drives `illegal` high in that cycle and writes nothing.
- R8: `br_op` 1 (any-of-2 false) is taken when either of `cc_out[base]` and `cc_out[base+1]` is 0. `br_op` 2 (any-of-2 true) is taken when either of those bits is 1. For both, `br_base` must be even.
- R9: `br_op` 3 (any-of-4 false) is taken when any of `cc_out[base..base+3]` is 0. `br_op` 4 (any-of-4 true) is taken when any of those bits is 1. For both, `br_base` must be a multiple of 4.
- R10: A branch whose base is misaligned for its width drives `illegal` high and is not taken. `br_op` values 0, 5, 6 and 7 are never taken and never raise `illegal`.
- R11: The branch decision uses the registered bits. A branch in the same cycle as a compare sees the old bits, and a branch in the next cycle sees the new ones.
- R12: While `cmp_valid` is 0, `cc_out` holds its value whatever the other compare inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_valid | input | 1 | Apply a compare in this cycle |
| cmp_fmt | input | 2 | Operand format: 0 single, 1 double, 2 paired single, 3 reserved |
| cmp_pred | input | 2 | Compare relation: 0 le, 1 lt, 2 eq, 3 unordered |
| cmp_idx | input | 3 | Target condition-bit index |
| op_a | input | 64 | Operand A |
| op_b | input | 64 | Operand B |
| br_op | input | 3 | Branch kind: 0 none, 1 any2-false, 2 any2-true, 3 any4-false, 4 any4-true |
| br_base | input | 3 | Base index of the tested group |
| cc_out | output | 8 | Condition-code register |
| br_taken | output | 1 | Branch decision for this cycle |
| illegal | output | 1 | Misaligned compare, reserved format, or misaligned branch |

## Verification
The assertions assume that `rst` is held high until the first clock edges have passed, and that the inputs are never X while `rst` is low. The bench keeps to this by driving every input to a defined value before reset is released. It changes inputs only just after a rising edge.

The NaN check is written only for the single-precision lane. It relies on the bench driving NaNs with a nonzero payload, so that they are not mistaken for infinities. The bench therefore draws its operands from a fixed set that keeps zeros of both signs, infinities and a quiet NaN distinct from the normal values.

Misaligned indices are applied on purpose. The assertions then only require that nothing is written and nothing is taken.

// File: rtl/magcmp_pkg.sv
package magcmp_pkg;

    localparam int CC_BITS  = 8;
    localparam int SGL_BITS = 32;
    localparam int SGL_EXPB = 8;
    localparam int DBL_BITS = 64;
    localparam int DBL_EXPB = 11;

    typedef enum logic [1:0] {
        FMT_SGL  = 2'd0,
        FMT_DBL  = 2'd1,
        FMT_PAIR = 2'd2,
        FMT_RSV  = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        PR_LE = 2'd0,
        PR_LT = 2'd1,
        PR_EQ = 2'd2,
        PR_UN = 2'd3
    } pred_e;

    typedef enum logic [2:0] {
        BR_NONE  = 3'd0,
        BR_ANY2F = 3'd1,
        BR_ANY2T = 3'd2,
        BR_ANY4F = 3'd3,
        BR_ANY4T = 3'd4,
        BR_RSV5  = 3'd5,
        BR_RSV6  = 3'd6,
        BR_RSV7  = 3'd7
    } brop_e;

    // Relation of two magnitudes, sign bits already dropped.
    typedef struct packed {
        logic nan;
        logic lt;
        logic eq;
    } magrel_t;

    function automatic logic pred_apply(pred_e p, magrel_t r);
        logic res;
        if (p == PR_UN) begin
            res = r.nan;
        end else if (r.nan) begin
            res = 1'b0;
        end else begin
            case (p)
                PR_LE:   res = r.lt | r.eq;
                PR_LT:   res = r.lt;
                default: res = r.eq;
            endcase
        end
        return res;
    endfunction

endpackage

// File: rtl/magcmp_lane.sv
module magcmp_lane
    import magcmp_pkg::*;
#(
    parameter int W  = 32,
    parameter int EW = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output magrel_t      rel
);
    localparam int MW = W - EW - 1;

    logic [W-2:0] mag_a;
    logic [W-2:0] mag_b;
    logic         nan_a;
    logic         nan_b;

    // Dropping the sign leaves an unsigned code that orders like the magnitude.
    assign mag_a = a[W-2:0];
    assign mag_b = b[W-2:0];

    assign nan_a = (&a[W-2 -: EW]) & (|a[MW-1:0]);
    assign nan_b = (&b[W-2 -: EW]) & (|b[MW-1:0]);

    always_comb begin
        rel.nan = nan_a | nan_b;
        rel.lt  = mag_a < mag_b;
        rel.eq  = mag_a == mag_b;
    end

endmodule

// File: rtl/cc_file.sv
module cc_file #(
    parameter int CC_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [CC_W-1:0] we,
    input  logic [CC_W-1:0] wd,
    output logic [CC_W-1:0] q
);
    logic [CC_W-1:0] q_r;

    generate
        for (genvar i = 0; i < CC_W; i++) begin : g_bit
            always_ff @(posedge clk) begin
                if (rst) begin
                    q_r[i] <= 1'b0;
                end else if (we[i]) begin
                    q_r[i] <= wd[i];
                end
            end
        end
    endgenerate

    assign q = q_r;

    // R2: a bit without a write enable keeps its value across the edge
    p_keep_unselected_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((q ^ $past(q)) & ~$past(we)) == '0);

endmodule

// File: rtl/ccbr_eval.sv
module ccbr_eval
    import magcmp_pkg::*;
#(
    parameter int CC_W = 8,
    parameter int IW   = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [CC_W-1:0] cc,
    input  logic [2:0]      op,
    input  logic [IW-1:0]   base,
    output logic            taken,
    output logic            misaligned
);
    brop_e           opc;
    logic [CC_W-1:0] sel2;
    logic [CC_W-1:0] sel4;
    logic            hit;

    assign opc = brop_e'(op);

    // Group membership for the aligned 2-bit and 4-bit windows.
    generate
        for (genvar i = 0; i < CC_W; i++) begin : g_sel
            assign sel2[i] = (IW'(i) >> 1) == (base >> 1);
            assign sel4[i] = (IW'(i) >> 2) == (base >> 2);
        end
    endgenerate

    always_comb begin
        hit        = 1'b0;
        misaligned = 1'b0;
        case (opc)
            BR_ANY2F: begin
                misaligned = base[0];
                hit        = |(sel2 & ~cc);
            end
            BR_ANY2T: begin
                misaligned = base[0];
                hit        = |(sel2 & cc);
            end
            BR_ANY4F: begin
                misaligned = |base[1:0];
                hit        = |(sel4 & ~cc);
            end
            BR_ANY4T: begin
                misaligned = |base[1:0];
                hit        = |(sel4 & cc);
            end
            default: begin
                hit        = 1'b0;
                misaligned = 1'b0;
            end
        endcase
        taken = hit & ~misaligned;
    end

    // R10: a misaligned base never yields a taken branch
    p_misaligned_not_taken_r10: assert property (@(posedge clk) disable iff (rst)
        misaligned |-> !taken);

    // R9: an any-of-4 false branch implies some zero in the aligned quad
    p_any4f_has_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (taken && opc == BR_ANY4F) |-> ((~cc & sel4) != '0));

    // R8: an any-of-2 true branch implies some one in the aligned pair
    p_any2t_has_one_r8: assert property (@(posedge clk) disable iff (rst)
        (taken && opc == BR_ANY2T) |-> ((cc & sel2) != '0));

    // R10: reserved opcodes never branch
    p_reserved_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (opc == BR_NONE || op > 3'd4) |-> (!taken && !misaligned));

endmodule

// File: rtl/magcmp_ccbr_unit.sv
module magcmp_ccbr_unit
    import magcmp_pkg::*;
#(
    parameter int CC_W     = CC_BITS,
    parameter int SGL_W    = SGL_BITS,
    parameter int SGL_EXP  = SGL_EXPB,
    parameter int DBL_W    = DBL_BITS,
    parameter int DBL_EXP  = DBL_EXPB,
    localparam int IW      = $clog2(CC_W),
    localparam int LANES   = DBL_W / SGL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmp_valid,
    input  logic [1:0]       cmp_fmt,
    input  logic [1:0]       cmp_pred,
    input  logic [IW-1:0]    cmp_idx,
    input  logic [DBL_W-1:0] op_a,
    input  logic [DBL_W-1:0] op_b,
    input  logic [2:0]       br_op,
    input  logic [IW-1:0]    br_base,
    output logic [CC_W-1:0]  cc_out,
    output logic             br_taken,
    output logic             illegal
);
    fmt_e             fmt;
    pred_e            pred;
    magrel_t          rel_lane [LANES];
    magrel_t          rel_dbl;
    logic [LANES-1:0] res_lane;
    logic             res_dbl;
    logic             res_one;
    logic             cmp_bad;
    logic             cmp_ok;
    logic             br_bad;
    logic [CC_W-1:0]  cc_we;
    logic [CC_W-1:0]  cc_wd;
    logic [CC_W-1:0]  cc_q;

    assign fmt  = fmt_e'(cmp_fmt);
    assign pred = pred_e'(cmp_pred);

    // Single-precision lanes; lane 0 also serves the scalar single format.
    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            magcmp_lane #(.W(SGL_W), .EW(SGL_EXP)) u_lane (
                .a   (op_a[l*SGL_W +: SGL_W]),
                .b   (op_b[l*SGL_W +: SGL_W]),
                .rel (rel_lane[l])
            );
            assign res_lane[l] = pred_apply(pred, rel_lane[l]);
        end
    endgenerate

    magcmp_lane #(.W(DBL_W), .EW(DBL_EXP)) u_dbl (
        .a   (op_a),
        .b   (op_b),
        .rel (rel_dbl)
    );
    assign res_dbl = pred_apply(pred, rel_dbl);

    assign res_one = (fmt == FMT_DBL) ? res_dbl : res_lane[0];

    assign cmp_bad = cmp_valid & ((fmt == FMT_RSV) | ((fmt == FMT_PAIR) & cmp_idx[0]));
    assign cmp_ok  = cmp_valid & ~cmp_bad;

    // Write-enable and write-data per condition bit.
    generate
        for (genvar i = 0; i < CC_W; i++) begin : g_wr
            localparam int LN = i % LANES;
            always_comb begin
                if (fmt == FMT_PAIR) begin
                    cc_we[i] = cmp_ok & ((IW'(i) >> 1) == (cmp_idx >> 1));
                    cc_wd[i] = res_lane[LN];
                end else begin
                    cc_we[i] = cmp_ok & (IW'(i) == cmp_idx);
                    cc_wd[i] = res_one;
                end
            end
        end
    endgenerate

    cc_file #(.CC_W(CC_W)) u_cc (
        .clk (clk),
        .rst (rst),
        .we  (cc_we),
        .wd  (cc_wd),
        .q   (cc_q)
    );

    ccbr_eval #(.CC_W(CC_W), .IW(IW)) u_br (
        .clk        (clk),
        .rst        (rst),
        .cc         (cc_q),
        .op         (br_op),
        .base       (br_base),
        .taken      (br_taken),
        .misaligned (br_bad)
    );

    assign cc_out  = cc_q;
    assign illegal = cmp_bad | br_bad;

    // ---------------- assertions ----------------
    function automatic logic [CC_W-1:0] pair_bits(logic [IW-1:0] n);
        logic [CC_W-1:0] m;
        m = '0;
        m[{n[IW-1:1], 1'b0}] = 1'b1;
        m[{n[IW-1:1], 1'b1}] = 1'b1;
        return m;
    endfunction

    logic s_a_nan;
    assign s_a_nan = (&op_a[SGL_W-2 -: SGL_EXP]) & (|op_a[SGL_W-SGL_EXP-2:0]);

    // R7: a rejected compare leaves the register untouched
    p_illegal_nowrite_r7: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && illegal && br_op == 3'd0) |=> $stable(cc_out));

    // R12: no compare, no change
    p_idle_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !cmp_valid |=> $stable(cc_out));

    // R6: NaN in operand A of a scalar single compare yields a cleared bit
    p_nan_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && cmp_fmt == 2'd0 && cmp_pred != 2'd3 && s_a_nan)
        |=> !cc_out[$past(cmp_idx)]);

    // R4: a paired write touches only its aligned pair
    p_pair_confined_r4: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && !cmp_bad && cmp_fmt == 2'd2)
        |=> ((cc_out ^ $past(cc_out)) & ~pair_bits($past(cmp_idx))) == '0);

endmodule

// File: tb/tb_magcmp_ccbr_unit.sv
`timescale 1ns/1ps
module tb_magcmp_ccbr_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmp_valid = 1'b0;
    logic [1:0]  cmp_fmt = 2'd0;
    logic [1:0]  cmp_pred = 2'd0;
    logic [2:0]  cmp_idx = 3'd0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic [2:0]  br_op = 3'd0;
    logic [2:0]  br_base = 3'd0;
    logic [7:0]  cc_out;
    logic        br_taken;
    logic        illegal;

    always #2.5 clk = ~clk;

    magcmp_ccbr_unit dut (
        .clk(clk), .rst(rst), .cmp_valid(cmp_valid), .cmp_fmt(cmp_fmt),
        .cmp_pred(cmp_pred), .cmp_idx(cmp_idx), .op_a(op_a), .op_b(op_b),
        .br_op(br_op), .br_base(br_base), .cc_out(cc_out),
        .br_taken(br_taken), .illegal(illegal)
    );

    typedef struct {
        logic [7:0] cc;
        logic       taken;
        logic       ill;
        string      tag;
    } item_t;

    item_t      sb[$];
    int         n_chk = 0;
    int         n_bad = 0;
    logic [7:0] cc_m = 8'h00;
    bit         ended = 0;

    localparam logic [31:0] F_ONE  = 32'h3F80_0000;
    localparam logic [31:0] F_MONE = 32'hBF80_0000;
    localparam logic [31:0] F_TWO  = 32'h4000_0000;
    localparam logic [31:0] F_MTWO = 32'hC000_0000;
    localparam logic [31:0] F_PZ   = 32'h0000_0000;
    localparam logic [31:0] F_NZ   = 32'h8000_0000;
    localparam logic [31:0] F_INF  = 32'h7F80_0000;
    localparam logic [31:0] F_MINF = 32'hFF80_0000;
    localparam logic [31:0] F_NAN  = 32'h7FC0_0000;
    localparam logic [31:0] F_HALF = 32'h3F00_0000;
    localparam logic [31:0] F_FOUR = 32'h4080_0000;

    function automatic logic [31:0] pick(int k);
        case (k)
            0: return F_ONE;   1: return F_MONE;  2: return F_TWO;
            3: return F_MTWO;  4: return F_PZ;    5: return F_NZ;
            6: return F_INF;   7: return F_MINF;  8: return F_NAN;
            default: return F_HALF;
        endcase
    endfunction

    // Widen a single (no subnormals in stimulus) to a double bit pattern.
    function automatic real s2r(logic [31:0] s);
        logic [63:0] d;
        if (s[30:23] == 8'h00)      d = 64'h0;
        else if (s[30:23] == 8'hFF) d = {1'b0, 11'h7FF, s[22:0], 29'h0};
        else d = {1'b0, 11'(int'(s[30:23]) - 127 + 1023), s[22:0], 29'h0};
        return $bitstoreal(d);
    endfunction

    function automatic logic rel_of(real ma, real mb, logic nan, logic [1:0] p);
        if (p == 2'd3) return nan;
        if (nan) return 1'b0;
        case (p)
            2'd0: return ma <= mb;
            2'd1: return ma < mb;
            default: return ma == mb;
        endcase
    endfunction

    function automatic logic s_res(logic [31:0] a, logic [31:0] b, logic [1:0] p);
        logic nan;
        nan = (a[30:23] == 8'hFF && a[22:0] != 0) || (b[30:23] == 8'hFF && b[22:0] != 0);
        return rel_of(s2r({1'b0, a[30:0]}), s2r({1'b0, b[30:0]}), nan, p);
    endfunction

    function automatic logic d_res(logic [63:0] a, logic [63:0] b, logic [1:0] p);
        logic nan;
        nan = (a[62:52] == 11'h7FF && a[51:0] != 0) || (b[62:52] == 11'h7FF && b[51:0] != 0);
        return rel_of($bitstoreal({1'b0, a[62:0]}), $bitstoreal({1'b0, b[62:0]}), nan, p);
    endfunction

    // Expected branch outcome from the requirement text (R8, R9, R10).
    function automatic void br_model(logic [2:0] op, logic [2:0] base, logic [7:0] cc,
                                     output logic tk, output logic il);
        int w;
        int g;
        logic want;
        tk = 1'b0; il = 1'b0;
        if (op == 3'd0 || op > 3'd4) return;
        w    = (op <= 3'd2) ? 2 : 4;
        want = (op == 3'd2 || op == 3'd4);
        if (int'(base) % w != 0) begin il = 1'b1; return; end
        g = (int'(base) / w) * w;
        for (int i = 0; i < w; i++) if (cc[g+i] == want) tk = 1'b1;
    endfunction

    task automatic apply(logic v, logic [1:0] f, logic [1:0] p, logic [2:0] idx,
                         logic [63:0] a, logic [63:0] b, logic [2:0] op,
                         logic [2:0] base, string tag);
        item_t it;
        logic tk, bil, cil;
        @(posedge clk); #1;
        cmp_valid = v; cmp_fmt = f; cmp_pred = p; cmp_idx = idx;
        op_a = a; op_b = b; br_op = op; br_base = base;
        br_model(op, base, cc_m, tk, bil);
        cil = v && (f == 2'd3 || (f == 2'd2 && idx[0]));
        it.cc = cc_m; it.taken = tk; it.ill = bil | cil; it.tag = tag;
        sb.push_back(it);
        if (v && !cil) begin
            case (f)
                2'd0: cc_m[idx] = s_res(a[31:0], b[31:0], p);
                2'd1: cc_m[idx] = d_res(a, b, p);
                default: begin
                    cc_m[idx]        = s_res(a[31:0], b[31:0], p);
                    cc_m[idx | 3'd1] = s_res(a[63:32], b[63:32], p);
                end
            endcase
        end
    endtask

    task automatic chk(string what, string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Monitor: compare registered and combinational outputs mid-cycle.
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                chk("cc_out", it.tag, cc_out, it.cc);
                chk("br_taken", it.tag, {7'b0, br_taken}, {7'b0, it.taken});
                chk("illegal", it.tag, {7'b0, illegal}, {7'b0, it.ill});
            end
        end
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL all-requirements watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("cc_out in reset", "R1", cc_out, 8'h00);
        chk("br_taken in reset", "R1", {7'b0, br_taken}, 8'h00);
        @(posedge clk); #1 rst = 1'b0;

        apply(0, 0, 0, 0, '0, '0, 3'd0, 0, "R1");
        // Scalar single: signs ignored
        apply(1, 0, 0, 3, {32'h0, F_MONE}, {32'h0, F_MTWO}, 0, 0, "R2");
        apply(1, 0, 0, 5, {32'h0, F_MTWO}, {32'h0, F_ONE}, 0, 0, "R2");
        apply(1, 0, 0, 6, {32'h0, F_ONE}, {32'h0, F_MTWO}, 0, 0, "R2");
        // Double: lower half alone would give the opposite answer
        apply(1, 1, 0, 6, 64'h3FF0_0000_8000_0000, 64'h3FE0_0000_0000_0001, 0, 0, "R3");
        apply(1, 1, 2, 2, 64'hC014_0000_0000_0000, 64'h4014_0000_0000_0000, 0, 0, "R3");
        // Paired: lower to idx, upper to idx+1
        apply(1, 2, 0, 0, {F_FOUR, F_MONE}, {F_MTWO, F_ONE}, 0, 0, "R4");
        apply(1, 2, 1, 4, {F_HALF, F_ONE}, {F_TWO, F_MONE}, 0, 0, "R4 R5");
        // Predicates
        apply(1, 0, 2, 7, {32'h0, F_NZ}, {32'h0, F_PZ}, 0, 0, "R5");
        apply(1, 0, 1, 7, {32'h0, F_TWO}, {32'h0, F_MTWO}, 0, 0, "R5");
        apply(1, 0, 0, 3, {32'h0, F_INF}, {32'h0, F_MINF}, 0, 0, "R5");
        // NaN
        apply(1, 0, 0, 3, {32'h0, F_NAN}, {32'h0, F_INF}, 0, 0, "R6");
        apply(1, 0, 3, 5, {32'h0, F_ONE}, {32'h0, F_NAN}, 0, 0, "R6");
        apply(1, 2, 2, 6, {F_NAN, F_PZ}, {F_NAN, F_NZ}, 0, 0, "R6");
        // Illegal compares
        apply(1, 2, 0, 3, {F_ONE, F_ONE}, {F_ONE, F_ONE}, 0, 0, "R7");
        apply(1, 3, 0, 2, {F_ONE, F_ONE}, {F_TWO, F_TWO}, 0, 0, "R7");
        // Idle
        apply(0, 0, 3, 1, {F_NAN, F_NAN}, {F_NAN, F_NAN}, 0, 0, "R12");
        apply(0, 2, 0, 0, '0, '0, 0, 0, "R12");
        // Branches over all aligned bases
        for (int op = 1; op <= 4; op++)
            for (int bs = 0; bs < 8; bs++)
                apply(0, 0, 0, 0, '0, '0, 3'(op), 3'(bs),
                      (op <= 2) ? ((bs % 2 != 0) ? "R8 R10" : "R8")
                                : ((bs % 4 != 0) ? "R9 R10" : "R9"));
        for (int op = 5; op <= 7; op++) apply(0, 0, 0, 0, '0, '0, 3'(op), 0, "R10");
        // Same-cycle vs next-cycle visibility
        apply(1, 1, 3, 4, '0, '0, 3'd3, 3'd4, "R11");
        apply(1, 2, 0, 4, {F_ONE, F_ONE}, {F_ONE, F_ONE}, 3'd4, 3'd4, "R11");
        apply(1, 2, 0, 6, {F_ONE, F_ONE}, {F_ONE, F_ONE}, 3'd3, 3'd4, "R11");
        apply(0, 0, 0, 0, '0, '0, 3'd3, 3'd4, "R11");
        // Mixed random stream
        for (int n = 0; n < 80; n++) begin
            logic [1:0] f;
            f = 2'($urandom_range(0, 3));
            apply(1'($urandom_range(0, 1)), f, 2'($urandom_range(0, 3)),
                  3'($urandom_range(0, 7)),
                  {pick($urandom_range(0, 9)), pick($urandom_range(0, 9))},
                  {pick($urandom_range(0, 9)), pick($urandom_range(0, 9))},
                  3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)),
                  "R2 R4 R5 R6 R8 R9");
        end
        apply(0, 0, 0, 0, '0, '0, 0, 0, "R12");
        @(posedge clk); @(negedge clk); @(negedge clk);
        finish_run();
    end

endmodule